// File: doc/BRIEF.md
# Load-Linked / Store-Conditional Reservation Monitor

This block holds one reservation for an atomic read-modify-write sequence issued by a single core. A load-linked access records the word address it touches and arms the reservation. A later store-conditional to the same word succeeds only if nothing has written that word in between. Writes are observed from the core's own plain stores and from a snoop port that carries the writes of every other agent. A write to any byte of the reserved word breaks the reservation.

On a store-conditional the block decides success in the same cycle. It raises the memory write enable only when the store succeeds, and it returns a flag word for the destination register: 1 on success and 0 on failure. Software retries the sequence while that flag reads 0. An exception entry or return input drops the reservation, and so does reset.

Top module: `llsc_monitor`

## Requirements
- R1: After reset no reservation is held, so a store-conditional issued before any load-linked fails with `mem_we_o`=0 and `rd_flag_o`=0.
- R2: A load-linked followed by a store-conditional to the same word, with no intervening write, succeeds. In the store-conditional cycle `sc_resp_o`=1, `sc_ok_o`=1, `mem_we_o`=1 and `rd_flag_o`=1.
- R3: Addresses are compared on the word only, ignoring `addr_i[1:0]`. A store-conditional to a different word fails, with `mem_we_o`=0 and `rd_flag_o`=0.
- R4: Every store-conditional clears the reservation, whether it succeeds or fails, so a second store-conditional without a new load-linked fails.
- R5: A snoop write (`snoop_we_i`=1) to any byte of the reserved word clears the reservation. A snoop write to another word leaves it intact.
- R6: A plain store from the core (op 2'b10) to the reserved word clears the reservation. A plain store to another word does not.
- R7: `flush_i` clears the reservation. A store-conditional in the same cycle as `flush_i` fails.
- R8: A new load-linked replaces any earlier reservation with its own word.
- R9: A snoop write to the reserved word in the same cycle as a store-conditional makes it fail. A snoop write to the load-linked's word in the load-linked's own cycle leaves no reservation.
- R10: Op encoding on `op_i` when `op_valid_i`=1: 2'b00 load, 2'b01 load-linked, 2'b10 store, 2'b11 store-conditional. A plain store drives `mem_we_o`=1. Loads, load-linked and idle cycles drive `mem_we_o`=0. `sc_resp_o` is 1 only in store-conditional cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| op_valid_i | input | 1 | Core access valid this cycle |
| op_i | input | 2 | Access kind (see R10) |
| addr_i | input | ADDR_W | Byte address of the core access |
| snoop_we_i | input | 1 | Write by another agent this cycle |
| snoop_addr_i | input | ADDR_W | Byte address of the snooped write |
| flush_i | input | 1 | Exception entry or return: drop reservation |
| mem_we_o | output | 1 | Memory write enable for the core access |
| sc_resp_o | output | 1 | Store-conditional result valid |
| sc_ok_o | output | 1 | Store-conditional succeeded |
| rd_flag_o | output | DATA_W | Value for the destination register of a store-conditional |

## Verification
The hardest cases to reach are collisions within a single cycle: a snoop write landing on the reserved word exactly as the store-conditional issues, and a snoop write hitting the word a load-linked is arming in that same cycle. Directed sequences line these up deliberately, using differing byte offsets so that the word-only comparison is also exercised. Random traffic then draws addresses from a pool of only four words, so that snoop hits, same-cycle overlaps and repeated reservations happen often. Each cycle is compared against a bench model of the reservation.

// File: rtl/llsc_pkg.sv
package llsc_pkg;
  typedef enum logic [1:0] {
    OP_LD = 2'b00,
    OP_LL = 2'b01,
    OP_ST = 2'b10,
    OP_SC = 2'b11
  } llsc_op_e;
endpackage

// File: rtl/llsc_word_cmp.sv
module llsc_word_cmp #(
  parameter int ADDR_W = 32,
  parameter int OFFS_W = 2
) (
  input  logic [ADDR_W-1:0] a_i,
  input  logic [ADDR_W-1:0] b_i,
  output logic              eq_o
);
  localparam int TAG_W = ADDR_W - OFFS_W;
  logic [TAG_W-1:0] a_tag, b_tag;
  assign a_tag = a_i[ADDR_W-1:OFFS_W];
  assign b_tag = b_i[ADDR_W-1:OFFS_W];
  assign eq_o  = (a_tag == b_tag);
endmodule

// File: rtl/llsc_resv_reg.sv
module llsc_resv_reg #(
  parameter int ADDR_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              set_i,
  input  logic [ADDR_W-1:0] set_addr_i,
  input  logic              clr_i,
  output logic              valid_o,
  output logic [ADDR_W-1:0] addr_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      addr_o  <= '0;
    end else if (set_i) begin
      valid_o <= 1'b1;
      addr_o  <= set_addr_i;
    end else if (clr_i) begin
      valid_o <= 1'b0;
    end
  end

  // R8
  set_loads_addr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i |=> (valid_o && addr_o == $past(set_addr_i)));
  // R5
  clr_drops_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !set_i) |=> !valid_o);
endmodule

// File: rtl/llsc_monitor.sv
module llsc_monitor
  import llsc_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int OFFS_W = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              op_valid_i,
  input  logic [1:0]        op_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              snoop_we_i,
  input  logic [ADDR_W-1:0] snoop_addr_i,
  input  logic              flush_i,
  output logic              mem_we_o,
  output logic              sc_resp_o,
  output logic              sc_ok_o,
  output logic [DATA_W-1:0] rd_flag_o
);
  llsc_op_e          op;
  logic              is_ll, is_st, is_sc;
  logic              resv_valid;
  logic [ADDR_W-1:0] resv_addr;
  logic              req_eq_resv, snp_eq_resv, snp_eq_req;
  logic              snp_hit_resv, snp_hit_req, st_hit, sc_ok;
  logic              set, clr;

  assign op    = llsc_op_e'(op_i);
  assign is_ll = op_valid_i && (op == OP_LL);
  assign is_st = op_valid_i && (op == OP_ST);
  assign is_sc = op_valid_i && (op == OP_SC);

  llsc_word_cmp #(.ADDR_W(ADDR_W), .OFFS_W(OFFS_W)) u_cmp_req (
    .a_i(addr_i), .b_i(resv_addr), .eq_o(req_eq_resv));
  llsc_word_cmp #(.ADDR_W(ADDR_W), .OFFS_W(OFFS_W)) u_cmp_snp (
    .a_i(snoop_addr_i), .b_i(resv_addr), .eq_o(snp_eq_resv));
  llsc_word_cmp #(.ADDR_W(ADDR_W), .OFFS_W(OFFS_W)) u_cmp_new (
    .a_i(snoop_addr_i), .b_i(addr_i), .eq_o(snp_eq_req));

  assign snp_hit_resv = snoop_we_i && resv_valid && snp_eq_resv;
  assign snp_hit_req  = snoop_we_i && snp_eq_req;
  assign st_hit       = is_st && resv_valid && req_eq_resv;
  assign sc_ok        = is_sc && resv_valid && req_eq_resv && !snp_hit_resv && !flush_i;

  // a racing write to the new word voids the load-linked at once
  assign set = is_ll && !flush_i && !snp_hit_req;
  assign clr = flush_i || is_sc || is_ll || snp_hit_resv || st_hit;

  llsc_resv_reg #(.ADDR_W(ADDR_W)) u_resv (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .set_i     (set),
    .set_addr_i(addr_i),
    .clr_i     (clr),
    .valid_o   (resv_valid),
    .addr_o    (resv_addr)
  );

  assign mem_we_o  = is_st || sc_ok;
  assign sc_resp_o = is_sc;
  assign sc_ok_o   = sc_ok;
  assign rd_flag_o = {{(DATA_W-1){1'b0}}, sc_ok};

  // R1
  no_resv_fail_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sc_resp_o && !resv_valid) |-> (!sc_ok_o && !mem_we_o));
  // R4
  sc_clears_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sc_resp_o |=> !resv_valid);
  // R7
  flush_clears_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> !resv_valid);
  // R2
  sc_we_gated_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sc_resp_o && mem_we_o) |-> (sc_ok_o && rd_flag_o[0]));
  // R10
  ok_only_on_sc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sc_ok_o |-> sc_resp_o);
endmodule

// File: tb/tb_llsc_monitor.sv
module tb_llsc_monitor;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 32;
  localparam int DW = 32;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic          op_valid_i = 1'b0;
  logic [1:0]    op_i = 2'b00;
  logic [AW-1:0] addr_i = '0;
  logic          snoop_we_i = 1'b0;
  logic [AW-1:0] snoop_addr_i = '0;
  logic          flush_i = 1'b0;
  logic          mem_we_o, sc_resp_o, sc_ok_o;
  logic [DW-1:0] rd_flag_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  bit            m_valid = 1'b0;
  logic [AW-3:0] m_tag = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  llsc_monitor dut (
    .clk_i(clk), .rst_ni(rst_ni), .op_valid_i(op_valid_i), .op_i(op_i),
    .addr_i(addr_i), .snoop_we_i(snoop_we_i), .snoop_addr_i(snoop_addr_i),
    .flush_i(flush_i), .mem_we_o(mem_we_o), .sc_resp_o(sc_resp_o),
    .sc_ok_o(sc_ok_o), .rd_flag_o(rd_flag_o)
  );

  function automatic logic [AW-3:0] wtag(input logic [AW-1:0] a);
    return a[AW-1:2];
  endfunction

  function automatic bit exp_ok(input bit v, input logic [1:0] o, input logic [AW-1:0] a,
                                input bit sw, input logic [AW-1:0] sa, input bit fl);
    return v && (o == 2'b11) && m_valid && (wtag(a) == m_tag)
           && !(sw && wtag(sa) == m_tag) && !fl;
  endfunction

  task automatic step(input string req, input bit v, input logic [1:0] o,
                      input logic [AW-1:0] a, input bit sw, input logic [AW-1:0] sa,
                      input bit fl);
    bit ok, we, rsp;
    @(negedge clk);
    op_valid_i = v; op_i = o; addr_i = a;
    snoop_we_i = sw; snoop_addr_i = sa; flush_i = fl;
    ok  = exp_ok(v, o, a, sw, sa, fl);
    rsp = v && (o == 2'b11);
    we  = (v && o == 2'b10) || ok;
    #1;
    checks++;
    if (sc_resp_o !== rsp || sc_ok_o !== ok || mem_we_o !== we ||
        rd_flag_o !== {{(DW-1){1'b0}}, ok}) begin
      errors++;
      $display("FAIL %s: resp/ok/we/flag act %b%b%b %0h exp %b%b%b %0h",
               req, sc_resp_o, sc_ok_o, mem_we_o, rd_flag_o, rsp, ok, we, ok);
    end
    // model update
    if (v && o == 2'b01 && !fl && !(sw && wtag(sa) == wtag(a))) begin
      m_valid = 1'b1; m_tag = wtag(a);
    end else if (fl || (v && (o == 2'b11 || o == 2'b01))
                 || (sw && m_valid && wtag(sa) == m_tag)
                 || (v && o == 2'b10 && m_valid && wtag(a) == m_tag)) begin
      m_valid = 1'b0;
    end
  endtask

  task automatic idle(input string req);
    step(req, 1'b0, 2'b00, '0, 1'b0, '0, 1'b0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    // R1 reset state
    step("R1", 1, 2'b11, 32'h100, 0, '0, 0);
    // R2 basic success
    step("R2", 1, 2'b01, 32'h200, 0, '0, 0);
    idle("R2");
    step("R2", 1, 2'b11, 32'h200, 0, '0, 0);
    // R4 second sc fails
    step("R4", 1, 2'b11, 32'h200, 0, '0, 0);
    // R3 byte offset ignored, other word fails
    step("R3", 1, 2'b01, 32'h301, 0, '0, 0);
    step("R3", 1, 2'b11, 32'h303, 0, '0, 0);
    step("R3", 1, 2'b01, 32'h300, 0, '0, 0);
    step("R3", 1, 2'b11, 32'h304, 0, '0, 0);
    step("R4", 1, 2'b11, 32'h300, 0, '0, 0);
    // R5 snoop other word keeps, same word byte clears
    step("R5", 1, 2'b01, 32'h400, 0, '0, 0);
    step("R5", 0, 2'b00, '0, 1, 32'h408, 0);
    step("R5", 1, 2'b11, 32'h400, 0, '0, 0);
    step("R5", 1, 2'b01, 32'h400, 0, '0, 0);
    step("R5", 0, 2'b00, '0, 1, 32'h402, 0);
    step("R5", 1, 2'b11, 32'h400, 0, '0, 0);
    // R6 own store
    step("R6", 1, 2'b01, 32'h500, 0, '0, 0);
    step("R6", 1, 2'b10, 32'h504, 0, '0, 0);
    step("R6", 1, 2'b11, 32'h500, 0, '0, 0);
    step("R6", 1, 2'b01, 32'h500, 0, '0, 0);
    step("R6", 1, 2'b10, 32'h501, 0, '0, 0);
    step("R6", 1, 2'b11, 32'h500, 0, '0, 0);
    // R7 flush
    step("R7", 1, 2'b01, 32'h600, 0, '0, 0);
    step("R7", 0, 2'b00, '0, 0, '0, 1);
    step("R7", 1, 2'b11, 32'h600, 0, '0, 0);
    step("R7", 1, 2'b01, 32'h600, 0, '0, 0);
    step("R7", 1, 2'b11, 32'h600, 0, '0, 1);
    // R8 replacement
    step("R8", 1, 2'b01, 32'h700, 0, '0, 0);
    step("R8", 1, 2'b01, 32'h710, 0, '0, 0);
    step("R8", 1, 2'b11, 32'h700, 0, '0, 0);
    step("R8", 1, 2'b01, 32'h700, 0, '0, 0);
    step("R8", 1, 2'b01, 32'h710, 0, '0, 0);
    step("R8", 1, 2'b11, 32'h710, 0, '0, 0);
    // R9 same-cycle races
    step("R9", 1, 2'b01, 32'h800, 0, '0, 0);
    step("R9", 1, 2'b11, 32'h800, 1, 32'h803, 0);
    step("R9", 1, 2'b01, 32'h900, 1, 32'h901, 0);
    step("R9", 1, 2'b11, 32'h900, 0, '0, 0);
    // R10 plain ops
    step("R10", 1, 2'b10, 32'hA00, 0, '0, 0);
    step("R10", 1, 2'b00, 32'hA00, 0, '0, 0);
    step("R10", 1, 2'b01, 32'hA00, 0, '0, 0);
    idle("R10");
    // random mix, word pool of four
    void'($urandom(32'd1234));
    for (int i = 0; i < 3000; i++) begin
      logic [AW-1:0] a, sa;
      a  = {26'h0, 2'($urandom_range(0, 3)), 2'b00, 2'($urandom_range(0, 3))};
      sa = {26'h0, 2'($urandom_range(0, 3)), 2'b00, 2'($urandom_range(0, 3))};
      step("R2", ($urandom_range(0, 7) != 0), 2'($urandom_range(0, 3)), a,
           ($urandom_range(0, 3) == 0), sa, ($urandom_range(0, 31) == 0));
    end
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule